// File: doc/BRIEF.md
# NAND Sector Hamming ECC Generator and Checker

This block computes a 24-bit single-error-correcting parity code over a NAND flash sector of 512 bytes. The sector arrives one byte per clock on a valid/data pair, framed by a start pulse. Every accepted byte updates a pair of 12-bit parity accumulators that a write path can store in the spare area. The pairs are indexed by the bit's 12-bit address, which is the byte index concatenated with the bit position. The stored form is the bitwise inverse of the parity. As a result, a freshly erased sector (all bytes 0xFF) whose spare bytes also read 0xFF checks clean.

On a read, the code held in the spare area is presented together with a compare strobe. The block XORs it with the freshly computed code and classifies the difference. The four outcomes are: clean, a single flipped data bit (with byte index and one-hot flip mask), a single flipped bit inside the stored code (harmless, no data change), or uncorrectable. Applying the flip to the sector buffer is left to the surrounding logic.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset, codeOut is 0xFFFFFF, sectorDone is 0, chkValid is 0, and chkStatus, errByte and flipMask are all zero.
- R2: Take a data bit at byte b and bit k, and form the 12-bit address a = {b[8:0], k[2:0]}. For each i, the bit toggles raw parity bit 12+i when a[i] is 1, and raw parity bit i when a[i] is 0. codeOut is the bitwise inverse of the raw parity, and codeOut[7:0] is the first of its three stored bytes. codeOut holds its value in any cycle with neither byteValid nor secStart.
- R3: secStart clears the parity, so codeOut reads 0xFFFFFF. If byteValid is high in the same cycle as secStart, that byte is taken as byte 0 of the new sector.
- R4: Only cycles with byteValid high advance the byte count. Idle gaps are allowed. sectorDone is a single-cycle pulse in the cycle after the 512th byte is accepted, and it is low at all other times.
- R5: A sector of all 0xFF bytes yields codeOut = 0xFFFFFF, and comparing it with a stored 0xFFFFFF reports clean.
- R6: The result of a compare is registered. chkValid is high for exactly the one cycle after cmpStrobe, and the outputs are all zero when chkValid is low. The compare uses the code held at the strobe edge, including when the strobe falls in the sectorDone cycle or coincides with secStart.
- R7: With diff = storedCode XOR codeOut, a zero diff reports chkStatus 0 (clean), with errByte 0 and flipMask 0.
- R8: If diff[23:12] XOR diff[11:0] equals 0xFFF and the byte index diff[23:15] is below the sector size, the block reports chkStatus 1 (data bit corrected). errByte is diff[23:15], and flipMask is one-hot at bit position diff[14:12].
- R9: A diff with exactly one bit set reports chkStatus 2 (error in stored code), with errByte 0 and flipMask 0.
- R10: Any other nonzero diff, or a correctable pattern whose byte index is not below the sector size, reports chkStatus 3 (uncorrectable), with errByte 0 and flipMask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| secStart | input | 1 | Start of sector; clears the parity |
| byteValid | input | 1 | byteData is accepted this cycle |
| byteData | input | 8 | Sector data byte |
| sectorDone | output | 1 | Pulse one cycle after the last sector byte |
| codeOut | output | 24 | Inverted code; bits 7:0 are stored first |
| cmpStrobe | input | 1 | Compare storedCode against codeOut |
| storedCode | input | 24 | Code read back from the spare area |
| chkValid | output | 1 | Result outputs are valid this cycle |
| chkStatus | output | 2 | 0 clean, 1 data corrected, 2 code error, 3 uncorrectable |
| errByte | output | 9 | Byte index of the flipped data bit |
| flipMask | output | 8 | One-hot mask of the bit to flip |

## Verification
The compare strobe can land in the same cycle as sectorDone, and it can also land in the same cycle as secStart. The bench provokes both. It raises cmpStrobe in the sectorDone cycle with the model's code for the sector and expects a clean result. It then raises cmpStrobe together with secStart and expects the pre-clear code to be judged clean while codeOut returns to 0xFFFFFF. A further collision, secStart together with the first valid byte, is judged by comparing the final code with a model that takes that byte as byte 0.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_CODE  = 2'd2,
    ST_FAIL  = 2'd3
  } chk_status_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAcc;
    logic accEn;
    logic cmpEn;
  } ecc_ctrl_t;

endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int IDX_W = $clog2(SECTOR_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             secStart,
  input  logic             byteValid,
  input  logic             cmpStrobe,
  output ecc_ctrl_t        ctrl,
  output logic [IDX_W-1:0] byteIdx,
  output logic             sectorDone
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_BYTES - 1);

  logic [IDX_W-1:0] byteCnt;
  logic             lastByte;

  // a byte on the start cycle is byte 0 of the new sector
  assign byteIdx  = secStart ? '0 : byteCnt;
  assign lastByte = byteValid && (byteIdx == LAST_IDX);

  always_comb begin
    ctrl.clrAcc = secStart;
    ctrl.accEn  = byteValid;
    ctrl.cmpEn  = cmpStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt    <= '0;
      sectorDone <= 1'b0;
    end else begin
      sectorDone <= lastByte;
      if (byteValid)
        byteCnt <= lastByte ? '0 : byteIdx + IDX_W'(1);
      else if (secStart)
        byteCnt <= '0;
    end
  end

  // R4
  done_after_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    sectorDone |-> $past(byteValid));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sectorDone |=> !sectorDone);

endmodule

// File: rtl/nand_ecc_datapath.sv
module nand_ecc_datapath
  import nand_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int IDX_W  = $clog2(SECTOR_BYTES),
  localparam int BIT_W  = 3,
  localparam int ADDR_W = IDX_W + BIT_W,
  localparam int CODE_W = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ecc_ctrl_t         ctrl,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic [7:0]        byteData,
  input  logic [CODE_W-1:0] storedCode,
  output logic [CODE_W-1:0] codeOut,
  output logic              chkValid,
  output logic [1:0]        chkStatus,
  output logic [IDX_W-1:0]  errByte,
  output logic [7:0]        flipMask
);

  // ---------------- parity accumulation ----------------
  logic [ADDR_W-1:0] evenPar, oddPar, evenNext, oddNext;
  logic [BIT_W-1:0]  colEven, colOdd;
  logic [IDX_W-1:0]  lineEven, lineOdd;
  logic              bytePar;

  assign bytePar = ^byteData;

  // column part: bit position inside the byte
  always_comb begin
    colEven = '0;
    colOdd  = '0;
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < BIT_W; i++) begin
        if (k[i]) colOdd[i]  = colOdd[i]  ^ byteData[k];
        else      colEven[i] = colEven[i] ^ byteData[k];
      end
    end
  end

  // line part: one pair per byte-index bit
  genvar g;
  for (g = 0; g < IDX_W; g++) begin : g_line
    assign lineEven[g] = byteIdx[g] ? 1'b0    : bytePar;
    assign lineOdd[g]  = byteIdx[g] ? bytePar : 1'b0;
  end

  always_comb begin
    evenNext = ctrl.clrAcc ? '0 : evenPar;
    oddNext  = ctrl.clrAcc ? '0 : oddPar;
    if (ctrl.accEn) begin
      evenNext = evenNext ^ {lineEven, colEven};
      oddNext  = oddNext  ^ {lineOdd,  colOdd};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evenPar <= '0;
      oddPar  <= '0;
    end else begin
      evenPar <= evenNext;
      oddPar  <= oddNext;
    end
  end

  // inverted so that an erased sector matches erased spare bytes
  assign codeOut = ~{oddPar, evenPar};

  // ---------------- compare and classify ----------------
  logic [CODE_W-1:0] diff;
  logic [ADDR_W-1:0] diffHi, diffLo;
  logic [IDX_W-1:0]  hitByte;
  logic [BIT_W-1:0]  hitBit;
  chk_status_e       statusNext;
  logic [IDX_W-1:0]  byteNext;
  logic [7:0]        maskNext;

  assign diff    = storedCode ^ codeOut;
  assign diffHi  = diff[CODE_W-1:ADDR_W];
  assign diffLo  = diff[ADDR_W-1:0];
  assign hitByte = diffHi[ADDR_W-1:BIT_W];
  assign hitBit  = diffHi[BIT_W-1:0];

  always_comb begin
    statusNext = ST_FAIL;
    byteNext   = '0;
    maskNext   = '0;
    if (diff == '0) begin
      statusNext = ST_CLEAN;
    end else if ((diffHi ^ diffLo) == '1) begin
      if ({1'b0, hitByte} < (IDX_W + 1)'(SECTOR_BYTES)) begin
        statusNext = ST_FIXED;
        byteNext   = hitByte;
        maskNext   = 8'(1) << hitBit;
      end
    end else if ($onehot(diff)) begin
      statusNext = ST_CODE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkValid  <= 1'b0;
      chkStatus <= ST_CLEAN;
      errByte   <= '0;
      flipMask  <= '0;
    end else if (ctrl.cmpEn) begin
      chkValid  <= 1'b1;
      chkStatus <= statusNext;
      errByte   <= byteNext;
      flipMask  <= maskNext;
    end else begin
      chkValid  <= 1'b0;
      chkStatus <= ST_CLEAN;
      errByte   <= '0;
      flipMask  <= '0;
    end
  end

  // R2
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.accEn && !ctrl.clrAcc) |=> $stable(codeOut));

  // R3
  clear_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.clrAcc && !ctrl.accEn) |=> (codeOut == '1));

  // R6
  result_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |-> $past(ctrl.cmpEn));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |-> (chkStatus == 2'd0 && errByte == '0 && flipMask == '0));

  // R8
  fix_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && chkStatus == ST_FIXED) |-> $onehot(flipMask));

  // R9 R10
  no_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkStatus == ST_CODE || chkStatus == ST_FAIL) |-> (flipMask == '0 && errByte == '0));

endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
  import nand_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int IDX_W  = $clog2(SECTOR_BYTES),
  localparam int CODE_W = 2 * (IDX_W + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secStart,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  output logic              sectorDone,
  output logic [CODE_W-1:0] codeOut,
  input  logic              cmpStrobe,
  input  logic [CODE_W-1:0] storedCode,
  output logic              chkValid,
  output logic [1:0]        chkStatus,
  output logic [IDX_W-1:0]  errByte,
  output logic [7:0]        flipMask
);

  ecc_ctrl_t        ctrl;
  logic [IDX_W-1:0] byteIdx;

  nand_ecc_ctrl #(.SECTOR_BYTES(SECTOR_BYTES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .secStart   (secStart),
    .byteValid  (byteValid),
    .cmpStrobe  (cmpStrobe),
    .ctrl       (ctrl),
    .byteIdx    (byteIdx),
    .sectorDone (sectorDone)
  );

  nand_ecc_datapath #(.SECTOR_BYTES(SECTOR_BYTES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .byteIdx    (byteIdx),
    .byteData   (byteData),
    .storedCode (storedCode),
    .codeOut    (codeOut),
    .chkValid   (chkValid),
    .chkStatus  (chkStatus),
    .errByte    (errByte),
    .flipMask   (flipMask)
  );

endmodule

// File: tb/nand_hamming_ecc_tb.sv
module nand_hamming_ecc_tb;

  localparam int NB = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secStart = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        cmpStrobe = 1'b0;
  logic [23:0] storedCode = '0;
  logic        sectorDone, chkValid;
  logic [23:0] codeOut;
  logic [1:0]  chkStatus;
  logic [8:0]  errByte;
  logic [7:0]  flipMask;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [7:0] sec [NB];

  always #4 clk = ~clk;

  nand_hamming_ecc u_dut (
    .clk(clk), .rstN(rstN), .secStart(secStart), .byteValid(byteValid),
    .byteData(byteData), .sectorDone(sectorDone), .codeOut(codeOut),
    .cmpStrobe(cmpStrobe), .storedCode(storedCode), .chkValid(chkValid),
    .chkStatus(chkStatus), .errByte(errByte), .flipMask(flipMask)
  );

  task automatic chkEq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // code per the parity definition of R2
  function automatic logic [23:0] modelCode();
    logic [11:0] lo, hi, a;
    lo = '0;
    hi = '0;
    for (int b = 0; b < NB; b++)
      for (int k = 0; k < 8; k++)
        if (sec[b][k]) begin
          a = {b[8:0], k[2:0]};
          for (int i = 0; i < 12; i++)
            if (a[i]) hi[i] = ~hi[i];
            else      lo[i] = ~lo[i];
        end
    return ~{hi, lo};
  endfunction

  function automatic logic [23:0] flipCode(int b, int k);
    logic [23:0] c;
    sec[b][k] = ~sec[b][k];
    c = modelCode();
    sec[b][k] = ~sec[b][k];
    return c;
  endfunction

  task automatic fillPattern(int seed);
    for (int i = 0; i < NB; i++) sec[i] = 8'((i * 37) ^ (i >> 3) ^ (seed * 91));
  endtask

  task automatic feedSector(int gap, bit startOnByte);
    int early = 0;
    if (!startOnByte) begin
      secStart = 1'b1;
      @(negedge clk);
      secStart = 1'b0;
    end
    for (int b = 0; b < NB; b++) begin
      if (startOnByte && b == 0) secStart = 1'b1;
      byteValid = 1'b1;
      byteData  = sec[b];
      @(negedge clk);
      secStart  = 1'b0;
      byteValid = 1'b0;
      if (b < NB - 1) begin
        if (sectorDone) early++;
        if (gap != 0 && b % gap == 0) begin
          repeat (2) begin
            @(negedge clk);
            if (sectorDone) early++;
          end
        end
      end
    end
    chkEq("R4", "sectorDone before last byte", early, 0);
    chkEq("R4", "sectorDone after last byte", sectorDone, 1);
  endtask

  task automatic compare(logic [23:0] st, logic [1:0] expSt, logic [8:0] expB,
                         logic [7:0] expM, string req);
    cmpStrobe  = 1'b1;
    storedCode = st;
    @(negedge clk);
    cmpStrobe = 1'b0;
    chkEq("R6", "chkValid", chkValid, 1);
    chkEq(req, "chkStatus", chkStatus, expSt);
    chkEq(req, "errByte", errByte, expB);
    chkEq(req, "flipMask", flipMask, expM);
    @(negedge clk);
    chkEq("R6", "chkValid idle", chkValid, 0);
    chkEq("R6", "outputs idle", {chkStatus, errByte, flipMask}, 0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chkEq("R1", "codeOut", codeOut, 24'hFFFFFF);
    chkEq("R1", "sectorDone", sectorDone, 0);
    chkEq("R1", "chkValid", chkValid, 0);
    chkEq("R1", "result outputs", {chkStatus, errByte, flipMask}, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testErased();
    for (int i = 0; i < NB; i++) sec[i] = 8'hFF;
    feedSector(0, 1'b0);
    chkEq("R5", "erased codeOut", codeOut, 24'hFFFFFF);
    compare(24'hFFFFFF, 2'd0, 9'd0, 8'd0, "R5");
  endtask

  task automatic testPattern();
    logic [23:0] exp;
    fillPattern(1);
    feedSector(0, 1'b0);
    exp = modelCode();
    chkEq("R2", "codeOut", codeOut, exp);
    repeat (3) @(negedge clk);
    chkEq("R2", "code held while idle", codeOut, exp);
    compare(exp, 2'd0, 9'd0, 8'd0, "R7");
  endtask

  task automatic testDataErr();
    compare(flipCode(300, 5), 2'd1, 9'd300, 8'h20, "R8");
    compare(flipCode(0, 0),   2'd1, 9'd0,   8'h01, "R8");
    compare(flipCode(511, 7), 2'd1, 9'd511, 8'h80, "R8");
  endtask

  task automatic testCodeErr();
    logic [23:0] exp;
    exp = modelCode();
    compare(exp ^ 24'h020000, 2'd2, 9'd0, 8'd0, "R9");
    compare(exp ^ 24'h000001, 2'd2, 9'd0, 8'd0, "R9");
  endtask

  task automatic testUncorr();
    logic [23:0] exp;
    exp = modelCode();
    compare(exp ^ 24'h000003, 2'd3, 9'd0, 8'd0, "R10");
    sec[10][1] = ~sec[10][1];
    sec[200][6] = ~sec[200][6];
    exp = modelCode();
    sec[10][1] = ~sec[10][1];
    sec[200][6] = ~sec[200][6];
    compare(exp, 2'd3, 9'd0, 8'd0, "R10");
  endtask

  task automatic testGaps();
    fillPattern(2);
    feedSector(5, 1'b0);
    chkEq("R4", "codeOut with gaps", codeOut, modelCode());
  endtask

  task automatic testStartOnByte();
    logic [23:0] exp;
    fillPattern(3);
    feedSector(0, 1'b1);
    exp = modelCode();
    chkEq("R3", "codeOut start with byte", codeOut, exp);
    // strobe in the sectorDone cycle
    compare(exp, 2'd0, 9'd0, 8'd0, "R6");
  endtask

  task automatic testStrobeWithStart();
    logic [23:0] exp;
    exp = modelCode();
    cmpStrobe  = 1'b1;
    secStart   = 1'b1;
    storedCode = exp;
    @(negedge clk);
    cmpStrobe = 1'b0;
    secStart  = 1'b0;
    chkEq("R6", "chkValid with start", chkValid, 1);
    chkEq("R6", "pre-clear compare", chkStatus, 2'd0);
    chkEq("R3", "cleared codeOut", codeOut, 24'hFFFFFF);
  endtask

  initial begin
    testReset();
    testErased();
    testPattern();
    testDataErr();
    testCodeErr();
    testUncorr();
    testGaps();
    testStartOnByte();
    testStrobeWithStart();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule